// File: doc/BRIEF.md
# Hierarchical Loop Pipeline Controller

This block is a parent controller for one outer loop whose body is split across a fixed chain of child stage controllers. Stage 0 is the head and each stage feeds the one after it. A pulse on `start_i` latches a run mode and a trip count. The controller then raises each child's enable, waits for that child's done pulse, and decides when every child may begin its next iteration. When the run is over it pulses `done_o` once. The scratchpads, FIFOs and datapaths that the children drive are outside the block. The block holds only the token, credit and enable bookkeeping.

There are three modes. In sequential mode, at most one child is enabled at any time, and the loop body runs stage by stage and iteration by iteration. In pipelined mode the parent feeds iterations into the head stage. A downstream stage runs an iteration only after its producer has finished that iteration. Each producer-to-consumer edge holds a credit count equal to the buffering depth, so a producer may never run more than that many iterations ahead of its consumer. In streaming mode every stage runs the full trip count on its own. A stage's enable is held low in any cycle in which its input FIFO reports empty or its output FIFO reports full.

Top module: `loop_pipe_ctrl`

## Requirements
- R1: During and directly after reset, all child enables, `done_o` and `credit_err_o` are low.
- R2: `start_i` is taken only while the controller is idle, and it latches `mode_i` and `trip_i` at that time. Later changes to `trip_i` do not alter the run: each child still completes exactly the latched number of iterations.
- R3: `mode_i` selects the run mode with this encoding: 0 = sequential, 1 = pipelined, 2 = streaming, 3 = sequential. In sequential mode no more than one child enable is high in any cycle. Within each iteration the stages run in order 0, 1, … N-1.
- R4: In sequential mode the schedule is fixed. The first enable appears 2 cycles after the cycle in which `start_i` is sampled. Each stage occupies L+1 cycles, where L is the number of enabled cycles it takes, including one idle gap. As a result, `done_o` rises exactly trip·Σ(L_i+1)+2 cycles after the start cycle.
- R5: In sequential and pipelined modes, stage i>0 never begins an iteration k before stage i-1 has completed iteration k. In pipelined mode, different stages run in parallel.
- R6: In pipelined mode, every edge's credit count starts at BUF_DEPTH. The count drops when the producer completes an iteration and rises when the consumer completes one. A producer does not start while its credit is zero. As a result, the number of completed-but-unconsumed iterations on an edge never exceeds BUF_DEPTH, and a slow consumer drives it up to BUF_DEPTH.
- R7: If a credit return and a credit decrement fall in the same cycle, the count is left unchanged.
- R8: In pipelined mode, a consumer done pulse that would raise a credit count above BUF_DEPTH leaves the count at BUF_DEPTH. It also raises `credit_err_o` for exactly one cycle, in the following cycle. In normal operation `credit_err_o` stays low.
- R9: In streaming mode, a child's enable is low in every cycle in which its `in_empty_i` bit or its `out_full_i` bit is high.
- R10: A child completes an iteration on a cycle where its enable and its done are both high. `done_o` is a single-cycle pulse that appears 2 cycles after the final completion of the run. It is high while every enable is low, and every child has then completed exactly the trip count.
- R11: A latched trip count of zero runs one iteration.
- R12: After `done_o` every counter is back at its reset value, so a following run behaves as a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the controller is idle |
| mode_i | input | 2 | Run mode, latched at start |
| trip_i | input | CNT_W | Outer-loop trip count, latched at start |
| child_done_i | input | N_STAGES | Per-child done pulse |
| in_empty_i | input | N_STAGES | Streaming: the child's input FIFO is empty |
| out_full_i | input | N_STAGES | Streaming: the child's output FIFO is full |
| child_en_o | output | N_STAGES | Per-child enable |
| done_o | output | 1 | One-cycle end-of-run pulse |
| credit_err_o | output | 1 | One-cycle pulse on a credit return above the depth |

## Verification
In pipelined mode, a credit return from the consumer and a credit decrement from the producer can land on the same edge in the same cycle. The bench provokes this with stages of equal latency, whose done pulses then coincide across neighbouring stages. It judges the outcome from the ports. A bench-side count of produced minus consumed iterations per edge must never exceed the depth. Every stage must still finish the trip count, and `done_o` must arrive exactly two cycles after the last completion. A separate run injects a stray consumer done while the credit is full, and it expects a single error pulse.

// File: rtl/loop_ctrl_pkg.sv
package loop_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_SEQ    = 2'd0,
    MODE_PIPE   = 2'd1,
    MODE_STREAM = 2'd2,
    MODE_SEQ_B  = 2'd3
  } run_mode_e;
endpackage

// File: rtl/loop_credit_cnt.sv
module loop_credit_cnt #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         take_i,
  input  logic         give_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] FULL = W'(DEPTH);

  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  // return with no matching decrement while already full
  assign ovf_o = give_i & ~take_i & (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= FULL;
    else if (clr_i)                             cnt_q <= FULL;
    else if (take_i & ~give_i)                  cnt_q <= cnt_q - 1'b1;
    else if (give_i & ~take_i & cnt_q != FULL)  cnt_q <= cnt_q + 1'b1;
  end

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> cnt_q != '0);
  p_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  p_same_cycle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && give_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/loop_stage_slot.sv
module loop_stage_slot #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             gate_i,
  input  logic             tok_add_i,
  input  logic             tok_take_i,
  output logic             active_o,
  output logic             en_o,
  output logic             fin_o,
  output logic [CNT_W-1:0] tok_o,
  output logic [CNT_W-1:0] st_cnt_o
);
  logic             active_q;
  logic [CNT_W-1:0] tok_q, st_q;

  assign active_o = active_q;
  assign en_o     = active_q & gate_i;
  assign fin_o    = en_o & done_i;
  assign tok_o    = tok_q;
  assign st_cnt_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tok_q    <= '0;
      st_q     <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      tok_q    <= '0;
      st_q     <= '0;
    end else begin
      if (start_i)    active_q <= 1'b1;
      else if (fin_o) active_q <= 1'b0;
      st_q  <= st_q + CNT_W'(start_i);
      tok_q <= tok_q + CNT_W'(tok_add_i) - CNT_W'(tok_take_i);
    end
  end

  p_tok_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_take_i |-> tok_q != '0);
endmodule

// File: rtl/loop_pipe_ctrl.sv
module loop_pipe_ctrl
  import loop_ctrl_pkg::*;
#(
  parameter int unsigned N_STAGES  = 3,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BUF_DEPTH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [CNT_W-1:0]    trip_i,
  input  logic [N_STAGES-1:0] child_done_i,
  input  logic [N_STAGES-1:0] in_empty_i,
  input  logic [N_STAGES-1:0] out_full_i,
  output logic [N_STAGES-1:0] child_en_o,
  output logic                done_o,
  output logic                credit_err_o
);
  localparam int unsigned CRED_W = $clog2(BUF_DEPTH + 1);

  logic             run_q, done_q, err_q;
  run_mode_e        mode_q;
  logic [CNT_W-1:0] trip_q;

  logic pipe_m, stream_m, seq_m, any_active, fin_all;
  logic [N_STAGES-1:0] active, fin, start, tok_nz, later_nz, cnt_full;
  logic [CNT_W-1:0]    st_cnt [N_STAGES];
  logic [CNT_W-1:0]    tok    [N_STAGES];
  logic [CRED_W-1:0]   cred   [N_STAGES-1];
  logic [N_STAGES-2:0] ovf;

  assign pipe_m     = (mode_q == MODE_PIPE);
  assign stream_m   = (mode_q == MODE_STREAM);
  assign seq_m      = ~pipe_m & ~stream_m;
  assign any_active = |active;
  assign fin_all    = run_q & (&cnt_full) & ~any_active;

  // pending tokens at any later stage block earlier stages in sequential mode
  always_comb begin
    for (int i = 0; i < N_STAGES; i++) later_nz[i] = |(tok_nz >> (i + 1));
  end

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    logic avail, ok, pipe_ok, gate, add, take;

    if (g == 0) begin : g_head
      assign add   = 1'b0;
      assign avail = st_cnt[g] < trip_q;
    end else begin : g_body
      assign add   = fin[g-1] & ~stream_m;
      assign avail = stream_m ? (st_cnt[g] < trip_q) : tok_nz[g];
    end

    if (g == N_STAGES - 1) begin : g_tail
      assign pipe_ok = 1'b1;
    end else begin : g_edge
      assign pipe_ok = cred[g] != '0;
      loop_credit_cnt #(.DEPTH(BUF_DEPTH), .W(CRED_W)) u_cred (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (fin_all),
        .take_i (fin[g] & pipe_m),
        .give_i (child_done_i[g+1] & run_q & pipe_m),
        .cnt_o  (cred[g]),
        .ovf_o  (ovf[g])
      );
    end

    assign ok = pipe_m   ? pipe_ok :
                stream_m ? 1'b1    : (~any_active & ~later_nz[g]);
    assign start[g]    = run_q & ~active[g] & avail & ok;
    assign take        = start[g] & (g != 0) & ~stream_m;
    assign gate        = stream_m ? (~in_empty_i[g] & ~out_full_i[g]) : 1'b1;
    assign tok_nz[g]   = tok[g] != '0;
    assign cnt_full[g] = st_cnt[g] == trip_q;

    loop_stage_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (fin_all),
      .start_i    (start[g]),
      .done_i     (child_done_i[g]),
      .gate_i     (gate),
      .tok_add_i  (add),
      .tok_take_i (take),
      .active_o   (active[g]),
      .en_o       (child_en_o[g]),
      .fin_o      (fin[g]),
      .tok_o      (tok[g]),
      .st_cnt_o   (st_cnt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_SEQ;
      trip_q <= CNT_W'(1);
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= fin_all;
      err_q  <= |ovf;
      if (!run_q && start_i) begin
        run_q  <= 1'b1;
        mode_q <= run_mode_e'(mode_i);
        trip_q <= (trip_i == '0) ? CNT_W'(1) : trip_i;
      end else if (fin_all) begin
        run_q <= 1'b0;
      end
    end
  end

  assign done_o       = done_q;
  assign credit_err_o = err_q;

  p_seq_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && seq_m) |-> $onehot0(child_en_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> child_en_o == '0);
endmodule

// File: tb/loop_pipe_ctrl_tb_top.sv
module loop_pipe_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int M  = 2;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [CW-1:0] trip = '0;
  logic [NS-1:0] cdone = '0, empty = '0, full = '0;
  logic [NS-1:0] en;
  logic          done, err;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_pipe_ctrl #(.N_STAGES(NS), .CNT_W(CW), .BUF_DEPTH(M)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .trip_i(trip),
    .child_done_i(cdone), .in_empty_i(empty), .out_full_i(full),
    .child_en_o(en), .done_o(done), .credit_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // child models: each takes lat[i] enabled cycles per iteration
  task automatic run_case(input int md, input int tr, input int l0, input int l1, input int l2,
                          input bit stall, input bit spur, input bit want_fill, input bit want_ovl);
    int lat[NS];
    int ecnt[NS];
    int fins[NS];
    int starts[NS];
    bit initer[NS];
    int exp_tr, c, last_fin, done_c, maxocc, s_sum, occ;
    bit bad_one, bad_gate, bad_order, bad_occ, bad_err, ovl;
    lat = '{l0, l1, l2};
    exp_tr = (tr == 0) ? 1 : tr;
    s_sum = 0;
    for (int i = 0; i < NS; i++) begin
      ecnt[i] = 0; fins[i] = 0; starts[i] = 0; initer[i] = 1'b0;
      s_sum += lat[i] + 1;
    end
    last_fin = -1; done_c = -1; maxocc = 0;
    bad_one = 0; bad_gate = 0; bad_order = 0; bad_occ = 0; bad_err = 0; ovl = 0;
    @(negedge clk);
    mode = 2'(md); trip = CW'(tr); start = 1'b1;
    @(negedge clk);
    start = 1'b0; trip = CW'(77);
    c = 1;
    while (done_c < 0 && c < 4000) begin
      for (int i = 0; i < NS; i++) begin
        empty[i] = stall && ((c + i) % 5 == 0);
        full[i]  = stall && ((c + 2*i) % 7 == 3);
      end
      cdone = '0;
      #1;
      if ($countones(en) > 1) begin
        ovl = 1;
        if (md == 0) bad_one = 1;
      end
      for (int i = 0; i < NS; i++) begin
        if (en[i]) begin
          if (!initer[i]) begin
            initer[i] = 1'b1;
            starts[i]++;
            if (md != 2 && i > 0 && starts[i] > fins[i-1]) bad_order = 1;
          end
          if (md == 2 && (empty[i] || full[i])) bad_gate = 1;
          ecnt[i]++;
          if (ecnt[i] == lat[i]) begin
            cdone[i] = 1'b1; ecnt[i] = 0; fins[i]++; initer[i] = 1'b0; last_fin = c;
          end
        end
      end
      if (spur && c == 1) cdone[1] = 1'b1;
      if (md == 1) begin
        for (int e = 0; e < NS - 1; e++) begin
          occ = fins[e] - fins[e+1];
          if (occ > maxocc) maxocc = occ;
          if (occ > M) bad_occ = 1;
        end
      end
      if (spur && c == 2) chk(err == 1'b1, "R8 error pulse", int'(err), 1);
      else if (spur && c == 3) chk(err == 1'b0, "R8 error one cycle", int'(err), 0);
      else if (err) bad_err = 1;
      if (done) begin
        done_c = c;
        chk(en == '0, "R10 enables low at done", int'(en), 0);
      end
      c++;
      if (done_c < 0) @(negedge clk);
    end
    cdone = '0; empty = '0; full = '0;
    chk(done_c >= 0, "R10 run completes", done_c, 1);
    for (int i = 0; i < NS; i++)
      chk(fins[i] == exp_tr, "R10 R2 R11 per-stage iterations", fins[i], exp_tr);
    chk(done_c == last_fin + 2, "R10 done timing", done_c, last_fin + 2);
    if (md == 0) begin
      chk(done_c == exp_tr * s_sum + 2, "R4 sequential schedule", done_c, exp_tr * s_sum + 2);
      chk(!bad_one, "R3 single enable", int'(bad_one), 0);
    end
    if (md != 2) chk(!bad_order, "R5 consumer after producer", int'(bad_order), 0);
    if (md == 1) chk(!bad_occ, "R6 occupancy bound", maxocc, M);
    if (want_fill) chk(maxocc == M, "R6 slow consumer fills buffer", maxocc, M);
    if (want_ovl) chk(ovl, "R5 pipelined overlap", int'(ovl), 1);
    if (md == 2) chk(!bad_gate, "R9 stream gating", int'(bad_gate), 0);
    if (!spur) chk(!bad_err, "R8 no spurious error", int'(bad_err), 0);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
    chk(en == '0, "R12 idle after done", int'(en), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(en == '0 && !done && !err, "R1 reset outputs", int'({en, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(en == '0 && !done && !err, "R1 after reset", int'({en, done, err}), 0);

    run_case(0, 3, 1, 2, 3, 0, 0, 0, 0); // R3 R4 sequential
    run_case(0, 1, 2, 1, 1, 0, 0, 0, 0);
    run_case(3, 2, 1, 1, 2, 0, 0, 0, 0); // R3 encoding 3 is sequential
    run_case(1, 5, 1, 1, 6, 0, 0, 1, 1); // R6 slow consumer
    run_case(1, 6, 2, 2, 2, 0, 0, 0, 1); // R7 coincident take and give
    run_case(1, 4, 3, 1, 1, 0, 1, 0, 0); // R8 stray return
    run_case(2, 4, 2, 3, 2, 1, 0, 0, 0); // R9 streaming with stalls
    run_case(2, 0, 1, 1, 1, 0, 0, 0, 0); // R11 zero trip
    run_case(0, 0, 1, 1, 1, 0, 0, 0, 0); // R11 zero trip, R12 back-to-back
    run_case(1, 3, 1, 2, 1, 0, 0, 0, 1); // R12 fresh credits

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule